// File: doc/BRIEF.md
# Memory-Card Command Engine

This block issues commands from a memory-card host controller and collects the card's replies. Software writes a 32-bit argument and then a command word. The command word holds a 6-bit index, a response-expected flag, a long-response flag and an enable bit.

Setting the enable bit starts a request toward the card side. The request is held until the card returns a reply or until a programmable cycle limit runs out. The reply's byte count is checked against the flags in the command word. A good reply is stored in four 32-bit response words, and the returned index is latched. Every outcome sets a sticky status flag. Software clears these flags through a write-one-to-clear register. Two interrupt lines each combine the status word with their own mask.

The register bus is a single-cycle write port with a combinational read port. Word addresses: 0 power, 1 clock, 2 argument, 3 command, 4 returned index, 5..8 response words 0..3, 9 status, 10 clear (write only, reads 0), 11 mask 0, 12 mask 1, 13 wait limit. Other addresses read 0.

Top module: `mmc_cmd_engine`

## Requirements
- R1: After reset, the following all read 0: status, command, argument, response words, returned index and both masks. The wait limit reads 32, `card_req_valid` is low and `irq` is 0.
- R2: The power and clock registers store only bits 7:0 of a write.
- R3: Writing the command register with bit 10 set starts a command. From the next cycle, `card_req_valid` is high and `card_req_index` equals bits 5:0. `card_req_arg` equals the argument register, and `card_req_long` equals bit 7. Status bit 11 reads 1 while the request is outstanding. A command write during that time is ignored.
- R4: When a command ends, for any reason, bit 10 of the command register reads 0. `card_req_valid` drops in the same cycle. Bits 9:0 keep their written value.
- R5: When bit 6 of the command word is 0, any card reply sets status bit 7. The response words are left unchanged.
- R6: When bit 6 is set and the reply is 4 bytes without bit 7, word 0 takes `card_rsp_data[127:96]`. Words 1 to 3 become 0, status bit 6 is set and the returned index register takes `card_rsp_index`.
- R7: A 16-byte reply to a command with bit 6 set is stored big-endian. Word k takes `card_rsp_data[127-32k -: 32]`, and bit 0 of word 3 is forced to 0. This holds whether bit 7 was set or not, and status bit 6 is set.
- R8: With bit 6 set, three replies set status bit 2 instead of bit 6 and leave the response words unchanged: a 0-byte reply, a 4-byte reply when bit 7 asked for a long reply, and any length other than 4 or 16.
- R9: With a wait limit of L, a command that gets no reply ends with status bit 2 set. Status bit 11 stays high for L+1 cycles after the launch, and the command ends at the following edge.
- R10: Writing the clear register clears each of status bits 10:0 that is 1 in the written value. Status bit 11 and written bits above 10 have no effect.
- R11: `irq[i]` is high exactly when the 12-bit status ANDed with mask register i is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| card_req_valid | output | 1 | Command outstanding toward the card |
| card_req_index | output | 6 | Command index |
| card_req_arg | output | 32 | Command argument |
| card_req_long | output | 1 | Long reply requested |
| card_rsp_valid | input | 1 | Card reply present this cycle |
| card_rsp_len | input | 5 | Reply byte count |
| card_rsp_index | input | 6 | Index returned by the card |
| card_rsp_data | input | 128 | Reply bytes, first byte in bits 127:120 |
| irq | output | 2 | Masked status interrupts |

## Verification
The engine is driven with several reply patterns, and each pattern reaches a different outcome. A reply to a command that expects nothing must set only the sent flag. A 4-byte reply to a short request must zero the upper words, while a 16-byte reply must fill all four words and clear the last bit. The three length mismatches (empty, short-for-long, odd length) must raise the timeout flag and leave earlier response words in place, so they are told apart from a good capture. A command with no reply is timed against the wait limit cycle by cycle. Clear writes that touch only other bits, or only the live active bit, show that the flags are sticky and that clearing is selective.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;
  localparam int STAT_W   = 12;
  localparam int STICKY_W = 11;
  localparam int ST_TMO   = 2;
  localparam int ST_RESP  = 6;
  localparam int ST_SENT  = 7;
  localparam int ST_ACT   = 11;
  localparam int CMD_W    = 11;
  localparam int CB_RESP  = 6;
  localparam int CB_LONG  = 7;
  localparam int CB_EN    = 10;
  localparam int NWORD    = 4;

  typedef enum logic [3:0] {
    RA_PWR = 4'd0, RA_CLK = 4'd1, RA_ARG = 4'd2, RA_CMD = 4'd3,
    RA_RIDX = 4'd4, RA_W0 = 4'd5, RA_W1 = 4'd6, RA_W2 = 4'd7,
    RA_W3 = 4'd8, RA_STAT = 4'd9, RA_CLR = 4'd10, RA_MSK0 = 4'd11,
    RA_MSK1 = 4'd12, RA_WAIT = 4'd13
  } reg_addr_e;

  // Reply length acceptable for the requested kind
  function automatic logic len_ok(input logic [4:0] len, input logic want_long);
    return (len == 5'd16) || (len == 5'd4 && !want_long);
  endfunction

  // Response word k from reply bytes; full selects 16-byte storage
  function automatic logic [31:0] rsp_word(input logic [127:0] d, input int k,
                                           input logic full);
    logic [31:0] w;
    w = d[127-32*k -: 32];
    if (!full && k != 0) w = '0;
    if (k == NWORD-1) w[0] = 1'b0;
    return w;
  endfunction
endpackage

// File: rtl/mmc_cmd_launch.sv
module mmc_cmd_launch
  import mmc_cmd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             expect_rsp,
  input  logic             want_long,
  input  logic             rsp_valid,
  input  logic [4:0]       rsp_len,
  input  logic [CNT_W-1:0] limit,
  output logic             active,
  output logic             ev_done,
  output logic             ev_sent,
  output logic             ev_resp,
  output logic             ev_tmo
);
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;
  logic             expired;

  assign active  = act_q;
  assign expired = act_q && !rsp_valid && (cnt_q == limit);
  assign ev_done = act_q && (rsp_valid || cnt_q == limit);
  assign ev_sent = act_q && rsp_valid && !expect_rsp;
  assign ev_resp = act_q && rsp_valid && expect_rsp && len_ok(rsp_len, want_long);
  assign ev_tmo  = expired ||
                   (act_q && rsp_valid && expect_rsp && !len_ok(rsp_len, want_long));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (go && !act_q) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (ev_done) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> !active);
  // R3
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ev_done) |=> active);
  // R9
  tmo_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !rsp_valid && cnt_q == limit) |-> ev_tmo);
endmodule

// File: rtl/mmc_rsp_capture.sv
module mmc_rsp_capture
  import mmc_cmd_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ev_resp,
  input  logic [4:0]                  rsp_len,
  input  logic [5:0]                  rsp_index,
  input  logic [127:0]                rsp_data,
  output logic [NWORD-1:0][31:0]      words,
  output logic [5:0]                  ridx
);
  logic full;
  assign full = (rsp_len == 5'd16);

  for (genvar k = 0; k < NWORD; k++) begin : g_word
    logic [31:0] w_q;
    always_ff @(posedge clk) begin
      if (!rst_n)       w_q <= '0;
      else if (ev_resp) w_q <= rsp_word(rsp_data, k, full);
    end
    assign words[k] = w_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ridx <= '0;
    else if (ev_resp) ridx <= rsp_index;
  end

  // R6
  short_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_resp && rsp_len == 5'd4) |=> (words[1] == '0 && words[2] == '0 && words[3] == '0));
  // R8
  words_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_resp |=> $stable(words));
endmodule

// File: rtl/mmc_stat_irq.sv
module mmc_stat_irq
  import mmc_cmd_pkg::*;
#(
  parameter int NIRQ = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [STICKY_W-1:0]           set_vec,
  input  logic                          clr_we,
  input  logic [31:0]                   clr_val,
  input  logic                          active,
  input  logic [NIRQ-1:0][STAT_W-1:0]   masks,
  output logic [STAT_W-1:0]             status,
  output logic [NIRQ-1:0]               irq
);
  logic [STICKY_W-1:0] sticky_q;
  logic [STICKY_W-1:0] clr_bits;

  assign clr_bits = clr_we ? clr_val[STICKY_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= (sticky_q & ~clr_bits) | set_vec;
  end

  assign status = {active, sticky_q};

  for (genvar i = 0; i < NIRQ; i++) begin : g_irq
    assign irq[i] = |(status & masks[i]);
    // R11
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_vec & masks[i][STICKY_W-1:0])) |=> irq[i]);
  end

  // R10
  clr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((sticky_q & $past(clr_val[STICKY_W-1:0] & ~set_vec)) == '0));
  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && set_vec == '0) |=> $stable(sticky_q));
endmodule

// File: rtl/mmc_cmd_engine.sv
module mmc_cmd_engine
  import mmc_cmd_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DEF_WAIT = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [3:0]   wr_addr,
  input  logic [31:0]  wr_data,
  input  logic [3:0]   rd_addr,
  output logic [31:0]  rd_data,
  output logic         card_req_valid,
  output logic [5:0]   card_req_index,
  output logic [31:0]  card_req_arg,
  output logic         card_req_long,
  input  logic         card_rsp_valid,
  input  logic [4:0]   card_rsp_len,
  input  logic [5:0]   card_rsp_index,
  input  logic [127:0] card_rsp_data,
  output logic [1:0]   irq
);
  localparam int NIRQ = 2;

  logic [7:0]                    pwr_q, clk_q;
  logic [31:0]                   arg_q;
  logic [CMD_W-1:0]              cmd_q;
  logic [CNT_W-1:0]              wait_q;
  logic [NIRQ-1:0][STAT_W-1:0]   mask_q;
  logic                          active, ev_done, ev_sent, ev_resp, ev_tmo;
  logic                          cmd_we, go, clr_we;
  logic [STICKY_W-1:0]           set_vec;
  logic [NWORD-1:0][31:0]        words;
  logic [5:0]                    ridx;
  logic [STAT_W-1:0]             status;

  assign cmd_we = wr_en && wr_addr == RA_CMD && !active;
  assign go     = cmd_we && wr_data[CB_EN];
  assign clr_we = wr_en && wr_addr == RA_CLR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q  <= '0;
      clk_q  <= '0;
      arg_q  <= '0;
      cmd_q  <= '0;
      wait_q <= CNT_W'(DEF_WAIT);
      mask_q <= '0;
    end else begin
      if (ev_done) cmd_q[CB_EN] <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          RA_PWR:  pwr_q     <= wr_data[7:0];
          RA_CLK:  clk_q     <= wr_data[7:0];
          RA_ARG:  arg_q     <= wr_data;
          RA_CMD:  if (!active) cmd_q <= wr_data[CMD_W-1:0];
          RA_MSK0: mask_q[0] <= wr_data[STAT_W-1:0];
          RA_MSK1: mask_q[1] <= wr_data[STAT_W-1:0];
          RA_WAIT: wait_q    <= wr_data[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  mmc_cmd_launch #(.CNT_W(CNT_W)) u_launch (
    .clk(clk), .rst_n(rst_n), .go(go),
    .expect_rsp(cmd_q[CB_RESP]), .want_long(cmd_q[CB_LONG]),
    .rsp_valid(card_rsp_valid), .rsp_len(card_rsp_len), .limit(wait_q),
    .active(active), .ev_done(ev_done), .ev_sent(ev_sent),
    .ev_resp(ev_resp), .ev_tmo(ev_tmo)
  );

  mmc_rsp_capture u_capture (
    .clk(clk), .rst_n(rst_n), .ev_resp(ev_resp), .rsp_len(card_rsp_len),
    .rsp_index(card_rsp_index), .rsp_data(card_rsp_data),
    .words(words), .ridx(ridx)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[ST_TMO]  = ev_tmo;
    set_vec[ST_RESP] = ev_resp;
    set_vec[ST_SENT] = ev_sent;
  end

  mmc_stat_irq #(.NIRQ(NIRQ)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_we(clr_we),
    .clr_val(wr_data), .active(active), .masks(mask_q),
    .status(status), .irq(irq)
  );

  assign card_req_valid = active;
  assign card_req_index = cmd_q[5:0];
  assign card_req_arg   = arg_q;
  assign card_req_long  = cmd_q[CB_LONG];

  always_comb begin
    case (rd_addr)
      RA_PWR:  rd_data = {24'd0, pwr_q};
      RA_CLK:  rd_data = {24'd0, clk_q};
      RA_ARG:  rd_data = arg_q;
      RA_CMD:  rd_data = 32'(cmd_q);
      RA_RIDX: rd_data = 32'(ridx);
      RA_W0:   rd_data = words[0];
      RA_W1:   rd_data = words[1];
      RA_W2:   rd_data = words[2];
      RA_W3:   rd_data = words[3];
      RA_STAT: rd_data = 32'(status);
      RA_MSK0: rd_data = 32'(mask_q[0]);
      RA_MSK1: rd_data = 32'(mask_q[1]);
      RA_WAIT: rd_data = 32'(wait_q);
      default: rd_data = '0;
    endcase
  end

  // R3
  idx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_req_valid && !ev_done) |=> $stable(card_req_index));
  // R4
  en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> !cmd_q[CB_EN]);
endmodule

// File: tb/test_mmc_cmd_engine.sv
module test_mmc_cmd_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [3:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [3:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic         card_req_valid;
  logic [5:0]   card_req_index;
  logic [31:0]  card_req_arg;
  logic         card_req_long;
  logic         card_rsp_valid = 1'b0;
  logic [4:0]   card_rsp_len = '0;
  logic [5:0]   card_rsp_index = '0;
  logic [127:0] card_rsp_data = '0;
  logic [1:0]   irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  localparam logic [127:0] DAT_A = 128'h00112233_44556677_8899AABB_CCDDEEFF;
  localparam logic [127:0] DAT_B = 128'hA1A2A3A4_B1B2B3B4_C1C2C3C4_D1D2D3D5;

  always #10 clk = ~clk;

  mmc_cmd_engine i_mmc_cmd_engine (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic reply(input logic [4:0] len, input logic [5:0] idx, input logic [127:0] d);
    @(negedge clk);
    card_rsp_valid = 1'b1; card_rsp_len = len; card_rsp_index = idx; card_rsp_data = d;
    @(posedge clk);
    @(negedge clk);
    card_rsp_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 req", card_req_valid, 0);
    chk("R1 irq", irq, 0);
    rdchk("R1 status", 4'd9, 0);
    rdchk("R1 cmd", 4'd3, 0);
    rdchk("R1 arg", 4'd2, 0);
    rdchk("R1 word0", 4'd5, 0);
    rdchk("R1 ridx", 4'd4, 0);
    rdchk("R1 mask0", 4'd11, 0);
    rdchk("R1 wait", 4'd13, 32);
  endtask

  task automatic t_pwrclk;
    wr(4'd0, 32'hFFFF_1234);
    wr(4'd1, 32'h0000_0A5C);
    rdchk("R2 power", 4'd0, 32'h34);
    rdchk("R2 clock", 4'd1, 32'h5C);
  endtask

  task automatic t_noresp;
    wr(4'd2, 32'hCAFE_0001);
    wr(4'd3, 32'h0000_0405);
    chk("R3 valid", card_req_valid, 1);
    chk("R3 index", card_req_index, 5);
    chk("R3 arg", card_req_arg, 32'hCAFE_0001);
    chk("R3 long", card_req_long, 0);
    rdchk("R3 active", 4'd9, 32'h800);
    wr(4'd3, 32'h0000_04FF);
    chk("R3 ignored", card_req_index, 5);
    reply(5'd0, 6'd0, DAT_A);
    chk("R4 valid drop", card_req_valid, 0);
    rdchk("R4 cmd", 4'd3, 32'h005);
    rdchk("R5 sent", 4'd9, 32'h080);
    rdchk("R5 words kept", 4'd5, 0);
    wr(4'd10, 32'hFFF);
  endtask

  task automatic t_short;
    wr(4'd3, 32'h0000_0451);
    reply(5'd4, 6'h11, DAT_A);
    rdchk("R6 w0", 4'd5, 32'h0011_2233);
    rdchk("R6 w1", 4'd6, 0);
    rdchk("R6 w3", 4'd8, 0);
    rdchk("R6 ridx", 4'd4, 32'h11);
    rdchk("R6 status", 4'd9, 32'h040);
    wr(4'd10, 32'hFFF);
  endtask

  task automatic t_long;
    wr(4'd3, 32'h0000_04C2);
    chk("R3 long", card_req_long, 1);
    reply(5'd16, 6'h3F, DAT_A);
    rdchk("R7 w0", 4'd5, 32'h0011_2233);
    rdchk("R7 w1", 4'd6, 32'h4455_6677);
    rdchk("R7 w2", 4'd7, 32'h8899_AABB);
    rdchk("R7 w3", 4'd8, 32'hCCDD_EEFE);
    rdchk("R7 status", 4'd9, 32'h040);
    rdchk("R4 cmd", 4'd3, 32'h0C2);
    wr(4'd10, 32'hFFF);
    wr(4'd3, 32'h0000_0443);
    reply(5'd16, 6'h03, DAT_B);
    rdchk("R7 full on short w1", 4'd6, 32'hB1B2_B3B4);
    rdchk("R7 full on short w3", 4'd8, 32'hD1D2_D3D4);
    wr(4'd10, 32'hFFF);
  endtask

  task automatic t_mismatch;
    for (int c = 0; c < 3; c++) begin
      logic [31:0] cw;
      logic [4:0]  ln;
      cw = (c == 1) ? 32'h04C4 : 32'h0444;
      ln = (c == 0) ? 5'd0 : (c == 1) ? 5'd4 : 5'd8;
      wr(4'd3, cw);
      reply(ln, 6'h22, DAT_A);
      rdchk("R8 status", 4'd9, 32'h004);
      rdchk("R8 w0 kept", 4'd5, 32'hA1A2_A3A4);
      rdchk("R8 ridx kept", 4'd4, 32'h03);
      wr(4'd10, 32'h004);
    end
  endtask

  task automatic t_timeout;
    wr(4'd13, 32'd5);
    wr(4'd11, 32'h004);
    wr(4'd12, 32'h800);
    wr(4'd3, 32'h0000_0447);
    chk("R11 active irq", irq, 2'b10);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R9 still active", card_req_valid, 1);
    end
    @(negedge clk);
    chk("R9 ended", card_req_valid, 0);
    rdchk("R9 status", 4'd9, 32'h004);
    chk("R11 tmo irq", irq, 2'b01);
    rdchk("R4 cmd", 4'd3, 32'h047);
  endtask

  task automatic t_clear;
    wr(4'd10, 32'h7FB);
    rdchk("R10 other bits", 4'd9, 32'h004);
    chk("R11 irq kept", irq, 2'b01);
    wr(4'd10, 32'h004);
    rdchk("R10 cleared", 4'd9, 0);
    chk("R11 irq low", irq, 2'b00);
    wr(4'd3, 32'h0000_0408);
    wr(4'd10, 32'hFFFF_F800);
    rdchk("R10 active kept", 4'd9, 32'h800);
    reply(5'd0, 6'd0, DAT_A);
    rdchk("R10 final", 4'd9, 32'h080);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pwrclk();
    t_noresp();
    t_short();
    t_long();
    t_mismatch();
    t_timeout();
    t_clear();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule